// File: doc/BRIEF.md
# Bernoulli Sampler Gate Array

This block draws random bits whose probability of being 1 is set by an unsigned weight. It holds a number of parallel sampling lanes. Each lane owns a 16-bit linear feedback shift register. On every draw the lane compares the low bits of its freshly stepped register with the weight. The lane yields 1 when the pseudorandom word is below the weight, so a weight of w on m bits gives a 1 with probability w/2^m.

Lane 0's bit is the single stochastic-gate output. The bits of all lanes are summed by an adder tree, which yields one binomial draw with n = lane count and p = w/2^m. Draws are requested with a one-cycle strobe, and results appear one clock later with a valid flag.

A seed port reloads every lane from one value. The lanes are decorrelated by a fixed per-lane mask, and an all-zero register is never allowed.

Top module: `bern_array`

## Requirements
- R1: For each draw, lane i's bit is 1 exactly when R_i < weight (unsigned), where R_i is the low WW bits (WW = 8 by default) of lane i's register after its step for that draw.
- R2: A draw steps each lane register s to {s[14:0], s[15]^s[13]^s[12]^s[10]}; no other cycle changes it except a seed load.
- R3: A weight of 0 makes every lane bit 0, so bit_out is 0 and count_out is 0.
- R4: A weight of all ones makes a lane bit 0 only when R_i is all ones.
- R5: When smp_req is high and seed_ld is low at a clock edge, out_vld is 1 in the following cycle and bit_out/count_out show that draw. In every other cycle out_vld is 0 and bit_out/count_out keep their last values.
- R6: count_out equals the number of lanes whose bit is 1. It lies in 0..LANES and is ceil(log2(LANES+1)) bits wide.
- R7: A seed_ld at a clock edge loads lane i with seed_val XOR (i*16'h1F35 mod 2^16), or with 16'hACE1 if that value is zero. A load takes priority over a simultaneous smp_req, which is then dropped with no valid.
- R8: After reset, out_vld, bit_out and count_out are 0, and the lanes hold the values a seed load of RST_SEED (default 16'h0001) would give.
- R9: Over many draws, the fraction of ones among all lane bits approaches weight/2^WW.
- R10: bit_out is the bit of lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_req | input | 1 | Request one draw on all lanes |
| weight | input | WW | Probability weight, P(1) = weight/2^WW |
| seed_ld | input | 1 | Reload all lane registers from seed_val |
| seed_val | input | 16 | Seed value |
| bit_out | output | 1 | Bernoulli sample (lane 0) |
| count_out | output | ceil(log2(LANES+1)) | Binomial sample, sum of lane bits |
| out_vld | output | 1 | Result of a draw is present this cycle |

## Verification
The assertions check the handshake and range properties on every cycle. out_vld follows only a draw that is not overridden by a load, outputs hold between draws, count_out never exceeds the lane count, a zero weight always yields a zero count, bit_out set implies a non-zero count, and no lane register is ever zero. Only the bench scenarios can show the exact bit values: the step sequence, the per-lane seed mask, the replacement of a zero seed, and the precedence of load over draw are checked against an independent register model. The long-run rate of ones against weight/2^WW is also visible only in the bench scenarios.

// File: rtl/bern_pkg.sv
package bern_pkg;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LANE_MASK = 16'h1F35;
  localparam logic [LFSR_W-1:0] ZERO_SUB  = 16'hACE1;

  // one step of the maximal-length shift register x^16+x^14+x^13+x^11+1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // per-lane seed derivation with zero substitution
  function automatic logic [LFSR_W-1:0] lane_seed(input logic [LFSR_W-1:0] seed,
                                                  input int unsigned     lane);
    logic [LFSR_W-1:0] m;
    m = seed ^ (LFSR_W'(lane) * LANE_MASK);
    return (m == '0) ? ZERO_SUB : m;
  endfunction

endpackage

// File: rtl/bern_lane.sv
module bern_lane #(
  parameter int unsigned WW       = 8,
  parameter int unsigned LANE_IDX = 0,
  parameter logic [15:0] RST_SEED = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load_en,
  input  logic [15:0]   seed_val,
  input  logic [WW-1:0] weight,
  output logic          draw_bit
);
  import bern_pkg::*;

  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] nxt_state;
  logic [WW-1:0]     rnd_word;

  assign nxt_state = lfsr_step(state);
  assign rnd_word  = nxt_state[WW-1:0];
  assign draw_bit  = (rnd_word < weight);

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= lane_seed(RST_SEED, LANE_IDX);
    else if (load_en) state <= lane_seed(seed_val, LANE_IDX);
    else if (step_en) state <= nxt_state;
  end

  // R7: the register never reaches the all-zero lock-up value
  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R2: without a load or a step the register holds its value
  a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(state));

endmodule

// File: rtl/bern_popcnt.sv
module bern_popcnt #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_in,
  output logic [CW-1:0] sum_out
);
  localparam int unsigned P = 1 << $clog2(N);

  always_comb begin
    logic [CW-1:0] lvl [P];
    for (int i = 0; i < P; i++) begin
      lvl[i] = (i < N) ? CW'(bits_in[i]) : '0;
    end
    for (int span = P / 2; span >= 1; span = span / 2) begin
      for (int i = 0; i < span; i++) begin
        lvl[i] = lvl[2*i] + lvl[2*i+1];
      end
    end
    sum_out = lvl[0];
  end

endmodule

// File: rtl/bern_array.sv
module bern_array #(
  parameter int unsigned WW       = 8,
  parameter int unsigned LANES    = 8,
  parameter logic [15:0] RST_SEED = 16'h0001,
  localparam int unsigned CW      = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_req,
  input  logic [WW-1:0] weight,
  input  logic          seed_ld,
  input  logic [15:0]   seed_val,
  output logic          bit_out,
  output logic [CW-1:0] count_out,
  output logic          out_vld
);

  logic             draw_go;
  logic [LANES-1:0] lane_bits;
  logic [CW-1:0]    lane_sum;
  logic [LANES-1:0] bits_q;
  logic [CW-1:0]    count_q;
  logic             vld_q;

  // load wins over a simultaneous draw request
  assign draw_go = smp_req & ~seed_ld;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bern_lane #(
      .WW       (WW),
      .LANE_IDX (g),
      .RST_SEED (RST_SEED)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (draw_go),
      .load_en  (seed_ld),
      .seed_val (seed_val),
      .weight   (weight),
      .draw_bit (lane_bits[g])
    );
  end

  bern_popcnt #(.N(LANES), .CW(CW)) u_sum (
    .bits_in (lane_bits),
    .sum_out (lane_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q  <= '0;
      count_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= draw_go;
      if (draw_go) begin
        bits_q  <= lane_bits;
        count_q <= lane_sum;
      end
    end
  end

  assign bit_out   = bits_q[0];
  assign count_out = count_q;
  assign out_vld   = vld_q;

  // R5: a draw not overridden by a load yields a valid next cycle
  a_r5_vld_after_draw: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !seed_ld) |=> out_vld);

  // R5: no valid without an accepted draw, and outputs hold
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_req && !seed_ld) |=> (!out_vld && $stable(count_out) && $stable(bit_out)));

  // R3: zero weight gives a zero binomial count
  a_r3_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !seed_ld && weight == '0) |=> (count_out == '0 && !bit_out));

  // R6: the count never exceeds the lane count
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    count_out <= CW'(LANES));

  // R10: lane 0 set implies a non-zero count
  a_r10_lane0_in_sum: assert property (@(posedge clk) disable iff (!rst_n)
    bit_out |-> (count_out != '0));

endmodule

// File: tb/sim_bern_array.sv
`timescale 1ns/1ps
module sim_bern_array;

  localparam int WW    = 8;
  localparam int LANES = 8;
  localparam int CW    = $clog2(LANES + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_req = 1'b0;
  logic [WW-1:0] weight = '0;
  logic          seed_ld = 1'b0;
  logic [15:0]   seed_val = '0;
  logic          bit_out;
  logic [CW-1:0] count_out;
  logic          out_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [15:0] mst [LANES];
  int lane0_last;

  always #4 clk = ~clk;

  bern_array #(.WW(WW), .LANES(LANES), .RST_SEED(16'h0001)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .weight(weight),
    .seed_ld(seed_ld), .seed_val(seed_val), .bit_out(bit_out),
    .count_out(count_out), .out_vld(out_vld)
  );

  // independent restatement of the step: feedback is the parity of the taps
  function automatic logic [15:0] m_step(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  function automatic logic [15:0] m_seed(input logic [15:0] s, input int i);
    logic [15:0] v;
    v = s ^ 16'(i * 32'h1F35);
    if (v == 16'h0000) v = 16'hACE1;
    return v;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_load(input logic [15:0] s);
    for (int i = 0; i < LANES; i++) mst[i] = m_seed(s, i);
  endtask

  task automatic do_load(input logic [15:0] s);
    seed_val = s; seed_ld = 1'b1;
    @(negedge clk);
    seed_ld = 1'b0;
    m_load(s);
    chk(out_vld, 0, "R7 no valid on load");
  endtask

  // draw on all lanes; returns the modelled count
  task automatic do_draw(input logic [WW-1:0] w, input bit check, input string tag,
                         output int exp_n);
    weight = w; smp_req = 1'b1;
    @(negedge clk);
    smp_req = 1'b0;
    exp_n = 0;
    for (int i = 0; i < LANES; i++) begin
      mst[i] = m_step(mst[i]);
      if (mst[i][WW-1:0] < w) exp_n++;
      if (i == 0) lane0_last = (mst[i][WW-1:0] < w) ? 1 : 0;
    end
    if (check) begin
      chk(out_vld, 1, {tag, " R5 valid"});
      chk(count_out, exp_n, {tag, " R6 count"});
      chk(bit_out, lane0_last, {tag, " R10 lane0 bit"});
    end
  endtask

  // stimulus table: {weight, seed}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd0,   16'h1234},   // R3
    {8'd255, 16'h0F0F},   // R4
    {8'd128, 16'hBEEF},   // R1
    {8'd1,   16'h8001},   // R1 low weight
    {8'd200, 16'h1F35},   // R7 lane 1 becomes zero -> substitute
    {8'd77,  16'h0000}    // R7 lane 0 becomes zero -> substitute
  };

  initial begin : main
    int e;
    int ones;
    int total;
    int c_prev;
    int b_prev;
    m_load(16'h0001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(out_vld, 0, "R8 reset valid");
    chk(count_out, 0, "R8 reset count");
    chk(bit_out, 0, "R8 reset bit");
    do_draw(8'd128, 1'b1, "R8 reset seeds", e);

    // R1 R2 R6 table walk
    for (int v = 0; v < NV; v++) begin
      do_load(VEC[v][15:0]);
      for (int k = 0; k < 4; k++) begin
        do_draw(VEC[v][23:16], 1'b1, "R1 R2 table", e);
        if (VEC[v][23:16] == 8'd0) chk(count_out, 0, "R3 zero weight");
      end
    end

    // R7 zero seed substitution made explicit on lane 0
    do_load(16'h0000);
    do_draw(8'd255, 1'b1, "R7 zero seed", e);
    chk(bit_out, (m_step(16'hACE1)[7:0] < 8'd255) ? 1 : 0, "R7 substitute value");

    // R5 hold: outputs stay, valid low for idle cycles
    c_prev = count_out; b_prev = bit_out;
    repeat (3) @(negedge clk);
    chk(out_vld, 0, "R5 idle valid");
    chk(count_out, c_prev, "R5 hold count");
    chk(bit_out, b_prev, "R5 hold bit");

    // R7 load beats draw; outputs unchanged, next draw runs from loaded state
    c_prev = count_out;
    seed_val = 16'h5A5A; seed_ld = 1'b1; smp_req = 1'b1; weight = 8'd128;
    @(negedge clk);
    seed_ld = 1'b0; smp_req = 1'b0;
    m_load(16'h5A5A);
    chk(out_vld, 0, "R7 priority valid");
    chk(count_out, c_prev, "R7 priority count held");
    do_draw(8'd128, 1'b1, "R7 after priority", e);

    // R9 long-run rate at weight 64: expect 1/4 of all lane bits
    ones = 0; total = 0;
    for (int k = 0; k < 3000; k++) begin
      do_draw(8'd64, 1'b0, "R9", e);
      if (out_vld !== 1'b1 || int'(count_out) != e) begin
        n_err++;
        $display("FAIL R9 draw %0d actual=%0d expected=%0d", k, count_out, e);
      end
      ones += count_out;
      total += LANES;
    end
    n_chk++;
    if (ones * 100 < total * 22 || ones * 100 > total * 28) begin
      n_err++;
      $display("FAIL R9 rate actual=%0d expected=%0d of %0d", ones, total / 4, total);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule